// File: doc/BRIEF.md
# Composite Sync Vertical Pulse Extractor

This block takes a composite sync waveform, where short line pulses and long frame pulses share one wire, and pulls the frame pulse out as an active-low vertical sync. One saturating up/down counter does the work, and it advances only on a sample tick. In measure mode the counter runs up while the sampled input is high and down while it is low. On every falling edge the count is captured into a threshold register. When the counter starts from zero, this captures the width of a positive line pulse in samples.

Software may rewrite the threshold to add a margin, and then selects an extract mode that matches the composite polarity. In extract mode the counter is reloaded from the threshold at the start of each pulse and steps toward a terminal count: zero for active-low input, full scale for active-high input. A pulse that lasts long enough to reach the terminal drives the vertical sync output low until the pulse ends. Two sticky clip flags record that the counter hit both ends of its range in measure mode. When both are set, the input is flagged as composite or as having changed polarity.

Top module: `csync_vext`

## Requirements
- R1: After reset, vsync_n is 1, cv_rd is 0, up_clip, down_clip and composite are 0, and the mode is measure.
- R2: A cycle with cv_wr high loads cv_wdata into the threshold register (seen on cv_rd) and into the counter, and clears both clip flags.
- R3: In measure mode each tick moves the counter up by one when the sampled input is 1 and down by one when it is 0, saturating at 0 and 31. A tick that tries to go above 31 sets up_clip, and one that tries to go below 0 sets down_clip. Both flags stay set until a cv_wr.
- R4: composite is 1 exactly when up_clip and down_clip are both 1.
- R5: In measure mode, a tick that samples a falling edge (previous sample 1, this sample 0) copies the counter value from before that tick into the threshold register. Starting from 0, this is the number of high samples in the pulse.
- R6: mode_wdata codes are 00 measure, 01 extract with active-low input, 10 extract with active-high input, and 11 behaves as measure. In measure mode vsync_n stays 1.
- R7: A cycle with mode_wr high (and no cv_wr) reloads the counter from the threshold register and drives vsync_n to 1.
- R8: In extract mode the tick that samples the start of a pulse reloads the counter from the threshold. Each later tick inside the pulse steps it one toward the terminal: decrement toward 0 for code 01, increment toward 31 for code 10. vsync_n goes to 0 on the tick whose stepped value equals the terminal.
- R9: vsync_n returns to 1 on the tick that samples the end of the pulse, so the output is active-low for either input polarity.
- R10: Counting in extract mode never changes up_clip or down_clip.
- R11: Changes of sync_in with tick low have no effect on vsync_n or cv_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 1 | Composite sync input, asynchronous |
| tick | input | 1 | Sample enable, one clock wide |
| cv_wr | input | 1 | Threshold and counter write strobe |
| cv_wdata | input | 5 | Value for the threshold write |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode code |
| cv_rd | output | 5 | Threshold register |
| up_clip | output | 1 | Sticky upper saturation flag |
| down_clip | output | 1 | Sticky lower saturation flag |
| composite | output | 1 | Both clip flags set |
| vsync_n | output | 1 | Extracted vertical sync, active low |

## Verification
Register writes show on cv_rd, the flags and vsync_n at the first clock edge that samples the strobe. The bench therefore drives each strobe for one clock from a falling edge and compares at the next falling edge. A level on sync_in passes through a two-stage synchronizer before the tick can use it, so its effects appear only at the edge where the tick is sampled. The bench holds each new level for three clocks before raising tick for one clock, and compares half a clock after that edge. The table and the directed cases therefore give expected values for every sample in terms of high and low sample counts.

// File: rtl/csx_pkg.sv
package csx_pkg;

   typedef enum logic [1:0] {
      CSX_MEASURE = 2'b00,
      CSX_EXT_NEG = 2'b01,
      CSX_EXT_POS = 2'b10,
      CSX_RSVD    = 2'b11
   } csx_mode_e;

   function automatic logic csx_extracting(input csx_mode_e m);
      return (m == CSX_EXT_NEG) || (m == CSX_EXT_POS);
   endfunction

   function automatic logic csx_active_level(input csx_mode_e m);
      return (m == CSX_EXT_POS);
   endfunction

endpackage

// File: rtl/csx_sampler.sv
module csx_sampler #(
   parameter int unsigned STAGES = 2,
   parameter bit          IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   input  logic tick,
   output logic level,
   output logic prev,
   output logic rise,
   output logic fall
);

   generate
      if (STAGES == 0) begin : g_direct
         assign level = sync_in;
      end else begin : g_sync
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= {STAGES{IDLE}};
            end else begin
               chain[0] <= sync_in;
               for (int i = 1; i < STAGES; i++) begin
                  chain[i] <= chain[i-1];
               end
            end
         end
         assign level = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= IDLE;
      end else if (tick) begin
         prev <= level;
      end
   end

   assign rise = tick &  level & ~prev;
   assign fall = tick & ~level &  prev;

endmodule

// File: rtl/csx_counter.sv
module csx_counter #(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          step,
   input  logic          up,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] cnt_next,
   output logic          clip_hi,
   output logic          clip_lo
);

   localparam logic [CW-1:0] TOP = {CW{1'b1}};
   localparam logic [CW-1:0] BOT = {CW{1'b0}};
   localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

   logic at_top, at_bot;

   always_comb begin
      at_top = (cnt == TOP);
      at_bot = (cnt == BOT);
      if (up) begin
         cnt_next = at_top ? cnt : cnt + ONE;
      end else begin
         cnt_next = at_bot ? cnt : cnt - ONE;
      end
   end

   assign clip_hi = step &  up & at_top;
   assign clip_lo = step & ~up & at_bot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= BOT;
      end else if (load) begin
         cnt <= load_val;
      end else if (step) begin
         cnt <= cnt_next;
      end
   end

endmodule

// File: rtl/csx_vsync.sv
module csx_vsync (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic extract,
   input  logic stepping,
   input  logic pulse_end,
   input  logic hit,
   output logic vsync_n
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vsync_n <= 1'b1;
      end else if (clear || !extract || pulse_end) begin
         vsync_n <= 1'b1;
      end else if (stepping && hit) begin
         vsync_n <= 1'b0;
      end
   end

endmodule

// File: rtl/csync_vext.sv
module csync_vext
   import csx_pkg::*;
#(
   parameter int unsigned CW          = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_in,
   input  logic          tick,
   input  logic          cv_wr,
   input  logic [CW-1:0] cv_wdata,
   input  logic          mode_wr,
   input  logic [1:0]    mode_wdata,
   output logic [CW-1:0] cv_rd,
   output logic          up_clip,
   output logic          down_clip,
   output logic          composite,
   output logic          vsync_n
);

   localparam logic [CW-1:0] TERM_HI = {CW{1'b1}};
   localparam logic [CW-1:0] TERM_LO = {CW{1'b0}};

   generate
      if (CW < 2 || CW > 16) begin : g_bad_cw
         $error("csync_vext: CW must lie in 2..16");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("csync_vext: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   csx_mode_e     mode_q;
   logic [CW-1:0] cv_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nx;
   logic [CW-1:0] ld_val;
   logic          lvl, prv, rise_s, fall_s;
   logic          ext, act_lvl, on_act, was_act;
   logic          start, active, pend;
   logic          writes, ld, step, up;
   logic          clip_hi, clip_lo, hit;
   logic          up_q, dn_q;

   csx_sampler #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_smp (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_in (sync_in),
      .tick    (tick),
      .level   (lvl),
      .prev    (prv),
      .rise    (rise_s),
      .fall    (fall_s)
   );

   always_comb begin
      ext     = csx_extracting(mode_q);
      act_lvl = csx_active_level(mode_q);
      on_act  = (lvl == act_lvl);
      was_act = (prv == act_lvl);
      start   = tick &  on_act & ~was_act;
      active  = tick &  on_act &  was_act;
      pend    = tick & ~on_act &  was_act;
      writes  = cv_wr | mode_wr;
      ld      = writes | (ext & start);
      ld_val  = cv_wr ? cv_wdata : cv_q;
      step    = ~writes & (ext ? active : tick);
      up      = ext ? act_lvl : lvl;
      hit     = (cnt_nx == (act_lvl ? TERM_HI : TERM_LO));
   end

   csx_counter #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .step     (step),
      .up       (up),
      .cnt      (cnt_q),
      .cnt_next (cnt_nx),
      .clip_hi  (clip_hi),
      .clip_lo  (clip_lo)
   );

   csx_vsync u_vs (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (mode_wr),
      .extract   (ext),
      .stepping  (step),
      .pulse_end (pend),
      .hit       (hit),
      .vsync_n   (vsync_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= CSX_MEASURE;
      end else if (mode_wr) begin
         mode_q <= csx_mode_e'(mode_wdata);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cv_q <= TERM_LO;
      end else if (cv_wr) begin
         cv_q <= cv_wdata;
      end else if (!ext && fall_s) begin
         cv_q <= cnt_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (cv_wr) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (!ext) begin
         up_q <= up_q | clip_hi;
         dn_q <= dn_q | clip_lo;
      end
   end

   assign cv_rd     = cv_q;
   assign up_clip   = up_q;
   assign down_clip = dn_q;
   assign composite = up_q & dn_q;

endmodule

// File: rtl/csync_vext_chk.sv
module csync_vext_chk #(
   parameter int unsigned CW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick,
   input logic          cv_wr,
   input logic [CW-1:0] cv_wdata,
   input logic          mode_wr,
   input logic [1:0]    mode_q,
   input logic [CW-1:0] cnt_q,
   input logic [CW-1:0] cv_q,
   input logic          up_clip,
   input logic          down_clip,
   input logic          vsync_n
);

   logic          measure;
   logic [CW-1:0] cnt_prev;
   logic          norm_prev;
   logic [CW-1:0] delta;

   assign measure = (mode_q == 2'b00) || (mode_q == 2'b11);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_prev  <= '0;
         norm_prev <= 1'b0;
      end else begin
         cnt_prev  <= cnt_q;
         norm_prev <= measure && !cv_wr && !mode_wr;
      end
   end

   assign delta = cnt_q - cnt_prev;

   p_measure_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      measure |-> vsync_n);

   p_fall_at_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vsync_n) |-> ($past(tick) && (cnt_q == '0 || cnt_q == '1)));

   p_rise_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vsync_n) |-> $past(tick || mode_wr));

   p_cv_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cv_wr |=> (cv_q == $past(cv_wdata) && cnt_q == $past(cv_wdata)
                 && !up_clip && !down_clip));

   p_mode_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && !cv_wr) |=> (cnt_q == $past(cv_q) && vsync_n));

   p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      norm_prev |-> (delta == '0 || delta == {{(CW-1){1'b0}}, 1'b1} || delta == '1));

   p_sticky_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(up_clip) || $fell(down_clip)) |-> $past(cv_wr));

endmodule

bind csync_vext csync_vext_chk #(.CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .cv_wr     (cv_wr),
   .cv_wdata  (cv_wdata),
   .mode_wr   (mode_wr),
   .mode_q    (mode_q),
   .cnt_q     (cnt_q),
   .cv_q      (cv_q),
   .up_clip   (up_clip),
   .down_clip (down_clip),
   .vsync_n   (vsync_n)
);

// File: tb/csync_vext_test.sv
module csync_vext_test;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 36;

   localparam logic [1:0] OP_SMP  = 2'd0;
   localparam logic [1:0] OP_CV   = 2'd1;
   localparam logic [1:0] OP_MODE = 2'd2;

   // entry: op[16:15] data[14:10] exp_vsync_n[9] exp_cv[8:4] req[3:0]
   localparam logic [16:0] VEC [NVEC] = '{
      {OP_CV,   5'd0,  1'b1, 5'd0,  4'd2},   // R2 clear
      {OP_SMP,  5'd0,  1'b1, 5'd0,  4'd5},   // R5 fall, count 0
      {OP_SMP,  5'd1,  1'b1, 5'd0,  4'd5},
      {OP_SMP,  5'd1,  1'b1, 5'd0,  4'd5},
      {OP_SMP,  5'd1,  1'b1, 5'd0,  4'd5},
      {OP_SMP,  5'd0,  1'b1, 5'd3,  4'd5},   // R5 three high samples
      {OP_SMP,  5'd0,  1'b1, 5'd3,  4'd5},
      {OP_CV,   5'd28, 1'b1, 5'd28, 4'd2},   // margin for positive
      {OP_MODE, 5'd2,  1'b1, 5'd28, 4'd7},
      {OP_SMP,  5'd1,  1'b1, 5'd28, 4'd8},   // start
      {OP_SMP,  5'd1,  1'b1, 5'd28, 4'd8},
      {OP_SMP,  5'd1,  1'b1, 5'd28, 4'd8},
      {OP_SMP,  5'd0,  1'b1, 5'd28, 4'd9},   // short pulse ends
      {OP_SMP,  5'd1,  1'b1, 5'd28, 4'd8},
      {OP_SMP,  5'd1,  1'b1, 5'd28, 4'd8},
      {OP_SMP,  5'd1,  1'b1, 5'd28, 4'd8},
      {OP_SMP,  5'd1,  1'b0, 5'd28, 4'd8},   // R8 reaches 31
      {OP_SMP,  5'd1,  1'b0, 5'd28, 4'd8},
      {OP_SMP,  5'd0,  1'b1, 5'd28, 4'd9},   // R9 end
      {OP_CV,   5'd2,  1'b1, 5'd2,  4'd2},
      {OP_MODE, 5'd1,  1'b1, 5'd2,  4'd7},
      {OP_SMP,  5'd1,  1'b1, 5'd2,  4'd9},
      {OP_SMP,  5'd0,  1'b1, 5'd2,  4'd8},   // start low pulse
      {OP_SMP,  5'd0,  1'b1, 5'd2,  4'd8},
      {OP_SMP,  5'd0,  1'b0, 5'd2,  4'd8},   // reaches 0
      {OP_SMP,  5'd0,  1'b0, 5'd2,  4'd8},
      {OP_SMP,  5'd1,  1'b1, 5'd2,  4'd9},
      {OP_SMP,  5'd0,  1'b1, 5'd2,  4'd8},
      {OP_SMP,  5'd0,  1'b1, 5'd2,  4'd8},
      {OP_SMP,  5'd1,  1'b1, 5'd2,  4'd9},   // two-sample pulse ignored
      {OP_MODE, 5'd3,  1'b1, 5'd2,  4'd6},   // R6 reserved code
      {OP_SMP,  5'd0,  1'b1, 5'd2,  4'd6},
      {OP_SMP,  5'd0,  1'b1, 5'd2,  4'd6},
      {OP_SMP,  5'd0,  1'b1, 5'd2,  4'd6},
      {OP_SMP,  5'd1,  1'b1, 5'd2,  4'd6},
      {OP_SMP,  5'd0,  1'b1, 5'd1,  4'd6}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_in = 1'b1;
   logic       tick = 1'b0;
   logic       cv_wr = 1'b0;
   logic [4:0] cv_wdata = '0;
   logic       mode_wr = 1'b0;
   logic [1:0] mode_wdata = '0;
   logic [4:0] cv_rd;
   logic       up_clip, down_clip, composite, vsync_n;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   csync_vext uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_in    (sync_in),
      .tick       (tick),
      .cv_wr      (cv_wr),
      .cv_wdata   (cv_wdata),
      .mode_wr    (mode_wr),
      .mode_wdata (mode_wdata),
      .cv_rd      (cv_rd),
      .up_clip    (up_clip),
      .down_clip  (down_clip),
      .composite  (composite),
      .vsync_n    (vsync_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_cv(input logic [4:0] d);
      @(negedge clk); cv_wr = 1'b1; cv_wdata = d;
      @(negedge clk); cv_wr = 1'b0;
   endtask

   task automatic wr_mode(input logic [1:0] m);
      @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
      @(negedge clk); mode_wr = 1'b0;
   endtask

   task automatic smp(input logic l);
      @(negedge clk); sync_in = l;
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", {vsync_n, cv_rd, up_clip, down_clip, composite}, {1'b1, 5'd0, 3'b000});

      for (int i = 0; i < NVEC; i++) begin
         logic [16:0] v;
         v = VEC[i];
         case (v[16:15])
            OP_CV:   wr_cv(v[14:10]);
            OP_MODE: wr_mode(v[11:10]);
            default: smp(v[10]);
         endcase
         chk($sformatf("R%0d step %0d", v[3:0], i), {vsync_n, cv_rd}, {v[9], v[8:4]});
      end

      // R8 negative extract with threshold 1, input already low
      wr_cv(5'd1);
      wr_mode(2'b01);
      smp(1'b0);
      chk("R8", vsync_n, 0);
      // R11 input change without tick
      @(negedge clk); sync_in = 1'b1;
      repeat (6) @(negedge clk);
      chk("R11", {vsync_n, cv_rd}, {1'b0, 5'd1});
      smp(1'b1);
      chk("R9", vsync_n, 1);

      // R3 and R4 saturation flags in measure mode
      wr_mode(2'b00);
      wr_cv(5'd0);
      for (int i = 0; i < 32; i++) smp(1'b1);
      chk("R3 up", {up_clip, down_clip, composite}, 3'b100);
      for (int i = 0; i < 32; i++) smp(1'b0);
      chk("R5 full scale", cv_rd, 31);
      chk("R4", {up_clip, down_clip, composite}, 3'b111);
      wr_cv(5'd0);
      chk("R2 flags clear", {up_clip, down_clip, composite}, 3'b000);

      // R10 clipping during positive extract leaves flags alone
      wr_cv(5'd30);
      wr_mode(2'b10);
      smp(1'b0);
      smp(1'b1);
      smp(1'b1);
      smp(1'b1);
      chk("R8 pos", vsync_n, 0);
      chk("R10", {up_clip, down_clip}, 2'b00);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule